// File: doc/BRIEF.md
# Configurable PLA Logic Array

This block is a programmable logic array that computes sum-of-products logic. It has `N_IN` inputs, `N_PROD` product lines and `N_OUT` outputs. Every crosspoint of both planes is a configuration flop. The first plane selects literals, meaning true or inverted copies of each input, and each product line ANDs its selected literals. The second plane selects which product lines are ORed into each output.

The configuration is loaded serially, one bit per clock while `cfg_en` is high. The whole bitstream has `N_PROD*(2*N_IN+N_OUT)` bits. The literal-selection bits come first and the product-selection bits follow. The bit shifted in first ends up at crosspoint index 0 once the full stream has been clocked in. While loading, the outputs are forced low. When `cfg_en` returns low, the array becomes a purely combinational function of `in_vec`. A product line with no selected literal gives 0, so spare lines never drive an output high.

Top module: `pla_array`

## Requirements
- R1: An active-low reset (`rst_n`) clears every crosspoint, and while it is asserted or after it is released, `out_vec` is all zeros for every value of `in_vec` until a configuration is loaded.
- R2: On every rising clock edge with `cfg_en` high, `cfg_bit` enters the top of the crosspoint chain and all bits move one place toward index 0. After TOTAL = N_PROD*(2*N_IN+N_OUT) such edges, the bit shifted first sits at index 0 and the bit shifted last at index TOTAL-1.
- R3: Literal-selection crosspoint for product line r and column c is at chain index r*2*N_IN + c. Column 2*i selects input i in true form and column 2*i+1 selects input i inverted.
- R4: Output-selection crosspoint for product line r and output o is at chain index N_PROD*2*N_IN + r*N_OUT + o.
- R5: A product line is the AND of its selected literals. A product line with no selected literal is 0. A line that selects both forms of one input is 0.
- R6: Output o is the OR of all product lines whose output-selection crosspoint for o is set.
- R7: While `cfg_en` is high, `out_vec` is all zeros whatever the crosspoints and inputs.
- R8: While `cfg_en` is low, the crosspoints hold their values whatever `cfg_bit` does. `out_vec` follows `in_vec` in the same cycle, with no register on the path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration chain |
| rst_n | input | 1 | Asynchronous active-low reset, clears all crosspoints |
| cfg_en | input | 1 | High: shift configuration and blank outputs |
| cfg_bit | input | 1 | Serial configuration data |
| in_vec | input | N_IN | Logic inputs |
| out_vec | output | N_OUT | Sum-of-products outputs |

## Verification
Loading and evaluation can fall in the same cycle: a reload can start while the inputs and the old configuration would drive an output high. The bench first sets the inputs so that the present configuration yields a 1, and checks that value. It then starts a new bitstream and samples `out_vec` halfway through the shift, where an all-zero result is required. After `cfg_en` falls, the outputs must match the new configuration on an exhaustive input sweep. This shows that the old and new crosspoints never mixed on the outputs and that no bit was lost in the chain.

// File: rtl/pla_array.sv
`timescale 1ns/1ps
module pla_array #(
  parameter int N_IN   = 4,
  parameter int N_PROD = 16,
  parameter int N_OUT  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_en,
  input  logic              cfg_bit,
  input  logic [N_IN-1:0]   in_vec,
  output logic [N_OUT-1:0]  out_vec
);
  localparam int COLS     = 2 * N_IN;
  localparam int AND_BITS = N_PROD * COLS;
  localparam int OR_BITS  = N_PROD * N_OUT;
  localparam int TOTAL    = AND_BITS + OR_BITS;

  logic [TOTAL-1:0]  xp;
  logic [COLS-1:0]   lit;
  logic [N_PROD-1:0] prod;
  logic [N_OUT-1:0]  sop;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      xp <= '0;
    else if (cfg_en) xp <= {cfg_bit, xp[TOTAL-1:1]};

  genvar i, r, o;
  generate
    for (i = 0; i < N_IN; i++) begin : g_lit
      assign lit[2*i]   =  in_vec[i];
      assign lit[2*i+1] = ~in_vec[i];
    end
    for (r = 0; r < N_PROD; r++) begin : g_row
      wire [COLS-1:0] sel = xp[r*COLS +: COLS];
      assign prod[r] = (|sel) & (&(lit | ~sel));
    end
    for (o = 0; o < N_OUT; o++) begin : g_out
      wire [N_PROD-1:0] pick;
      for (r = 0; r < N_PROD; r++) begin : g_pick
        assign pick[r] = xp[AND_BITS + r*N_OUT + o];
      end
      assign sop[o] = |(prod & pick);
    end
  endgenerate

  assign out_vec = cfg_en ? '0 : sop;

  a_r1_reset_clears: assert property (@(posedge clk) !rst_n |=> (xp == '0));
  a_r2_shift_entry: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_en |=> (xp[TOTAL-1] == $past(cfg_bit)));
  a_r8_hold_config: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_en |=> $stable(xp));
  a_r7_blank_on_load: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_en |-> (out_vec == '0));
  a_r6_out_needs_term: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vec != '0) |-> (prod != '0));
  a_r5_term_needs_literal: assert property (@(posedge clk) disable iff (!rst_n)
    (prod != '0) |-> (xp[AND_BITS-1:0] != '0));
endmodule

// File: tb/pla_array_tb_top.sv
`timescale 1ns/1ps
module pla_array_tb_top;
  localparam int N = 4, P = 16, M = 2;
  localparam int COLS = 2 * N, ANDB = P * COLS, TOTAL = P * (COLS + M);

  logic clk = 1'b0, rst_n = 1'b0, cfg_en = 1'b0, cfg_bit = 1'b0;
  logic [N-1:0] in_vec = '0;
  logic [M-1:0] out_vec;
  always #10 clk = ~clk;

  pla_array #(.N_IN(N), .N_PROD(P), .N_OUT(M)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_bit(cfg_bit),
    .in_vec(in_vec), .out_vec(out_vec));

  bit and_m [P][COLS];
  bit or_m  [P][M];

  typedef struct { logic [M-1:0] exp; string tag; } item_t;
  item_t q[$];
  item_t cur;
  event sample_ev;
  int total = 0, fails = 0;
  bit done = 1'b0;

  function automatic logic [M-1:0] model(input logic [N-1:0] v);
    logic [M-1:0] res = '0;
    for (int r = 0; r < P; r++) begin
      bit any = 1'b0, term = 1'b1;
      for (int c = 0; c < COLS; c++)
        if (and_m[r][c]) begin
          any = 1'b1;
          term = term & ((c % 2) ? ~v[c/2] : v[c/2]);
        end
      for (int o = 0; o < M; o++)
        if (any && term && or_m[r][o]) res[o] = 1'b1;
    end
    return res;
  endfunction

  function automatic bit bit_at(input int k);
    if (k < ANDB) return and_m[k / COLS][k % COLS];
    return or_m[(k - ANDB) / M][(k - ANDB) % M];
  endfunction

  function automatic void clear_cfg();
    for (int r = 0; r < P; r++) begin
      for (int c = 0; c < COLS; c++) and_m[r][c] = 1'b0;
      for (int o = 0; o < M; o++) or_m[r][o] = 1'b0;
    end
  endfunction

  task automatic push_check(input logic [M-1:0] e, input string tag);
    item_t it;
    it.exp = e; it.tag = tag;
    q.push_back(it);
    #1 ->sample_ev;
    #1;
  endtask

  initial forever begin
    @(sample_ev);
    while (q.size() > 0) begin
      cur = q.pop_front();
      total++;
      if (out_vec !== cur.exp) begin
        fails++;
        $display("FAIL %s: out_vec=%b expected %b", cur.tag, out_vec, cur.exp);
      end
    end
  end

  task automatic load(input bit quiet_chk);
    @(negedge clk);
    cfg_en = 1'b1;
    for (int k = 0; k < TOTAL; k++) begin
      cfg_bit = bit_at(k);
      if (quiet_chk && k == TOTAL / 2) push_check('0, "R7 blank while loading");
      @(negedge clk);
    end
    cfg_en = 1'b0;
    cfg_bit = 1'b0;
  endtask

  task automatic sweep(input string tag);
    for (int v = 0; v < (1 << N); v++) begin
      in_vec = v[N-1:0];
      push_check(model(in_vec), tag);
    end
  endtask

  initial begin
    #4000000;
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    clear_cfg();
    in_vec = 4'hF;
    repeat (2) @(negedge clk);
    push_check('0, "R1 held in reset");
    rst_n = 1'b1;
    @(negedge clk);
    sweep("R1 empty after reset");

    // config A: R3 literal columns, R4 output columns, R5 empty and contradictory rows
    and_m[0][0] = 1; and_m[0][2] = 1; and_m[0][7] = 1; or_m[0][0] = 1;
    and_m[1][1] = 1; or_m[1][1] = 1;
    or_m[2][0] = 1; or_m[2][1] = 1;
    and_m[3][4] = 1; and_m[3][5] = 1; or_m[3][1] = 1;
    load(1'b0);
    sweep("R3 R4 R5 R6 config A");

    // R7 overlap of reload and live evaluation
    in_vec = 4'h0;
    push_check(model(in_vec), "R6 pre-reload output high");
    clear_cfg();
    and_m[15][6] = 1; or_m[15][1] = 1;
    and_m[7][3] = 1; and_m[7][4] = 1; or_m[7][0] = 1; or_m[7][1] = 1;
    load(1'b1);
    sweep("R2 R6 config B");

    // R8 cfg_bit toggling with cfg_en low changes nothing
    for (int t = 0; t < 24; t++) begin
      @(negedge clk);
      cfg_bit = t[0] ^ t[2];
    end
    cfg_bit = 1'b0;
    sweep("R8 config held");

    // R1 reset in operation
    in_vec = 4'hC;
    @(negedge clk);
    rst_n = 1'b0;
    #2;
    push_check('0, "R1 async reset clears");
    @(negedge clk);
    rst_n = 1'b1;
    clear_cfg();
    sweep("R1 cleared after second reset");

    done = 1'b1;
    #5;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule